// File: doc/BRIEF.md
# Reversible-Gate Ripple Arithmetic Unit

This block is an N-bit arithmetic unit assembled only from reversible primitives. Each primitive is its own module with as many output lines as input lines and a one-to-one mapping between them. Each bit slice has three parts:

- A two-line XOR gate that makes a copy and an inverted copy of the B bit.
- A 4-to-1 selector built from three controlled-swap gates. It chooses the second operand bit Y from B, ~B, constant 0 or constant 1.
- A reversible full adder that forms A + Y + carry.

The slices pass their carries from bit 0 upward. The unit is purely combinational, so its outputs follow the inputs with no clock.

The two-bit select and the carry-in together pick the operation:

| Select | Carry-in 0 | Carry-in 1 |
|---|---|---|
| 00 | add | add with carry |
| 01 | subtract with borrow | subtract |
| 10 | transfer A | increment A |
| 11 | decrement A | transfer A |

A parameter chooses how the full adder is realised: either two cascaded three-line gates or a single four-line gate. Every gate output that feeds nothing is brought out on a garbage bus. The constant `GARBAGE_TOTAL` gives the width of that bus for cost reporting.

Top module: `rv_arith_unit`

## Requirements
- R1: With select 00, {cout_o, result_o} equals a_i + b_i + cin_i, computed WIDTH+1 bits wide.
- R2: With select 01, {cout_o, result_o} equals a_i + ~b_i + cin_i. With cin_i=1 this gives a_i - b_i, and cout_o=1 means no borrow. With cin_i=0 it gives a_i - b_i - 1.
- R3: With select 10, {cout_o, result_o} equals a_i + cin_i. cin_i=0 transfers A with cout_o=0, and cin_i=1 increments A.
- R4: With select 11, {cout_o, result_o} equals a_i + (2^WIDTH - 1) + cin_i. cin_i=0 decrements A. cin_i=1 transfers A with cout_o=1.
- R5: Incrementing an all-ones A gives result 0 with cout_o=1. Decrementing a zero A gives all ones with cout_o=0.
- R6: ADDER_KIND=0 (two three-line gates) and ADDER_KIND=1 (one four-line gate) give identical result_o and cout_o for every input.
- R7: Outputs are combinational. They settle within the same clock cycle as an input change, with no register stage.
- R8: In every slice, the selector passes operand bit B for select 00, ~B for 01, 0 for 10 and 1 for 11. Select bit 1 is the outer choice and select bit 0 the inner one.
- R9: In every slice, the full adder's {carry, sum} equals a + y + carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand before selection |
| cin_i | input | 1 | Carry-in into bit 0 |
| sel_i | input | 2 | Operand select (see the table above) |
| result_o | output | WIDTH | Sum output |
| cout_o | output | 1 | Carry out of the top bit |
| garbage_o | output | GARBAGE_TOTAL | Unused gate outputs, 7 per slice |

## Verification
The hardest situations to reach are full-length carry ripples: increment of all ones, decrement of zero and subtract of equal operands. In these cases every slice's carry depends on the slice below it. They only show up for particular operand values paired with one particular select and carry-in. The stimulus therefore sweeps every select, carry-in and operand combination at 4-bit width. The sweep drives both adder realisations side by side, so the two-gate and the one-gate carry paths are each compared against the same reference sum at every such corner.

// File: rtl/rv_arith_pkg.sv
package rv_arith_pkg;
  // Garbage lines left over by each building block
  localparam int FA_GARBAGE    = 2;
  localparam int MUX_GARBAGE   = 5;
  localparam int SLICE_GARBAGE = FA_GARBAGE + MUX_GARBAGE;

  // Adder realisation choices
  localparam int ADDER_TWO_GATE = 0;
  localparam int ADDER_ONE_GATE = 1;

  typedef enum logic [1:0] {
    OPND_B    = 2'b00,
    OPND_NOTB = 2'b01,
    OPND_ZERO = 2'b10,
    OPND_ONES = 2'b11
  } opnd_sel_e;
endpackage

// File: rtl/rv_gates.sv
// Two-line XOR gate: p = a, q = a ^ b
module rv_xor2 (
  input  logic a,
  input  logic b,
  output logic p,
  output logic q
);
  assign p = a;
  assign q = a ^ b;
endmodule

// Three-line controlled swap: a steers b and c
module rv_cswap (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = (~a & b) | (a & c);
  assign r = (a & b) | (~a & c);
endmodule

// Three-line half-adder gate: p = a, q = a ^ b, r = (a & b) ^ c
module rv_peres3 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ^ b;
  assign r = (a & b) ^ c;
endmodule

// Four-line full-adder gate; d is an ancilla (0 gives the carry on s)
module rv_fa4 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  logic axb;
  assign axb = a ^ b;
  assign p = a;
  assign q = axb;
  assign r = axb ^ c;
  assign s = ((axb & c) ^ (a & b)) ^ d;
endmodule

// File: rtl/rv_mux4.sv
// 4-to-1 selector from three controlled-swap gates; the sel0 copy is reused
module rv_mux4 (
  input  logic       sel0,
  input  logic       sel1,
  input  logic [3:0] in_v,
  output logic       y,
  output logic [rv_arith_pkg::MUX_GARBAGE-1:0] junk
);
  logic s0_copy, lo_q, lo_r, hi_q, hi_r;

  rv_cswap u_lo (.a(sel0),    .b(in_v[0]), .c(in_v[1]), .p(s0_copy), .q(lo_q), .r(lo_r));
  rv_cswap u_hi (.a(s0_copy), .b(in_v[2]), .c(in_v[3]), .p(junk[0]), .q(hi_q), .r(hi_r));
  rv_cswap u_out(.a(sel1),    .b(lo_q),    .c(hi_q),    .p(junk[1]), .q(y),    .r(junk[2]));

  assign junk[3] = lo_r;
  assign junk[4] = hi_r;

  always_comb begin
    // R8
    mux_pick_chk: assert (y == in_v[{sel1, sel0}])
      else $error("mux output does not follow select");
  end
endmodule

// File: rtl/rv_full_adder.sv
module rv_full_adder #(
  parameter int ADDER_KIND = rv_arith_pkg::ADDER_TWO_GATE
) (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic sum,
  output logic co,
  output logic [rv_arith_pkg::FA_GARBAGE-1:0] junk
);
  generate
    if (ADDER_KIND == rv_arith_pkg::ADDER_ONE_GATE) begin : g_one
      rv_fa4 u_fa (.a(a), .b(b), .c(ci), .d(1'b0),
                   .p(junk[0]), .q(junk[1]), .r(sum), .s(co));
    end else begin : g_two
      logic hx, hc;
      rv_peres3 u_first  (.a(a),  .b(b),  .c(1'b0), .p(junk[0]), .q(hx),  .r(hc));
      rv_peres3 u_second (.a(hx), .b(ci), .c(hc),   .p(junk[1]), .q(sum), .r(co));
    end
  endgenerate

  always_comb begin
    // R9
    fa_sum_chk: assert ({co, sum} == ({1'b0, a} + {1'b0, b} + {1'b0, ci}))
      else $error("full adder result wrong");
  end
endmodule

// File: rtl/rv_slice.sv
module rv_slice #(
  parameter int ADDER_KIND = rv_arith_pkg::ADDER_TWO_GATE
) (
  input  logic       a,
  input  logic       b,
  input  logic [1:0] sel,
  input  logic       ci,
  output logic       sum,
  output logic       co,
  output logic       y,
  output logic [rv_arith_pkg::SLICE_GARBAGE-1:0] junk
);
  import rv_arith_pkg::*;

  logic b_copy, b_inv;
  logic [3:0] cand;

  // b XOR 1 gives the inverse; the copy line feeds the selector
  rv_xor2 u_inv (.a(b), .b(1'b1), .p(b_copy), .q(b_inv));

  assign cand = {1'b1, 1'b0, b_inv, b_copy};

  rv_mux4 u_mux (.sel0(sel[0]), .sel1(sel[1]), .in_v(cand), .y(y),
                 .junk(junk[MUX_GARBAGE-1:0]));

  rv_full_adder #(.ADDER_KIND(ADDER_KIND)) u_fa (
    .a(a), .b(y), .ci(ci), .sum(sum), .co(co),
    .junk(junk[SLICE_GARBAGE-1:MUX_GARBAGE])
  );
endmodule

// File: rtl/rv_arith_unit.sv
module rv_arith_unit #(
  parameter int WIDTH      = 4,
  parameter int ADDER_KIND = rv_arith_pkg::ADDER_TWO_GATE,
  localparam int GARBAGE_TOTAL = WIDTH * rv_arith_pkg::SLICE_GARBAGE
) (
  input  logic [WIDTH-1:0]         a_i,
  input  logic [WIDTH-1:0]         b_i,
  input  logic                     cin_i,
  input  logic [1:0]               sel_i,
  output logic [WIDTH-1:0]         result_o,
  output logic                     cout_o,
  output logic [GARBAGE_TOTAL-1:0] garbage_o
);
  import rv_arith_pkg::*;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] opnd;

  assign carry[0] = cin_i;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      rv_slice #(.ADDER_KIND(ADDER_KIND)) u_slice (
        .a   (a_i[i]),
        .b   (b_i[i]),
        .sel (sel_i),
        .ci  (carry[i]),
        .sum (result_o[i]),
        .co  (carry[i+1]),
        .y   (opnd[i]),
        .junk(garbage_o[i*SLICE_GARBAGE +: SLICE_GARBAGE])
      );
    end
  endgenerate

  assign cout_o = carry[WIDTH];

  always_comb begin
    // R1
    add_path_chk: assert (!(sel_i == OPND_B) ||
        ({cout_o, result_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})))
      else $error("add path wrong");
    // R3
    transfer_chk: assert (!(sel_i == OPND_ZERO && !cin_i) || (result_o == a_i && !cout_o))
      else $error("transfer path wrong");
    // R4
    ones_pass_chk: assert (!(sel_i == OPND_ONES && cin_i) || (result_o == a_i && cout_o))
      else $error("decrement-with-carry path wrong");
  end
endmodule

// File: tb/rv_arith_unit_tb.sv
`timescale 1ns/1ps
module rv_arith_unit_tb;
  localparam int W = 4;
  localparam int GW = W * 7;

  typedef struct {
    logic [W-1:0] res;
    logic         co;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a, b;
  logic cin;
  logic [1:0] sel;
  logic [W-1:0] res0, res1;
  logic co0, co1;
  logic [GW-1:0] gb0, gb1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  rv_arith_unit #(.WIDTH(W), .ADDER_KIND(0)) u_dut (
    .a_i(a), .b_i(b), .cin_i(cin), .sel_i(sel),
    .result_o(res0), .cout_o(co0), .garbage_o(gb0));

  rv_arith_unit #(.WIDTH(W), .ADDER_KIND(1)) u_dut_alt (
    .a_i(a), .b_i(b), .cin_i(cin), .sel_i(sel),
    .result_o(res1), .cout_o(co1), .garbage_o(gb1));

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h sel=%b cin=%b)",
               tag, act, exp, a, b, sel, cin);
    end
  endtask

  // Driver: apply stimulus and push the reference result
  task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb,
                       input logic [1:0] ts, input logic tc);
    exp_t e;
    logic [W:0] opv, tot;
    @(posedge clk);
    #1;
    a = ta; b = tb; sel = ts; cin = tc;
    case (ts)
      2'b00:   opv = {1'b0, tb};
      2'b01:   opv = {1'b0, ~tb};
      2'b10:   opv = '0;
      default: opv = {1'b0, {W{1'b1}}};
    endcase
    tot = {1'b0, ta} + opv + {{W{1'b0}}, tc};
    e.res = tot[W-1:0];
    e.co  = tot[W];
    if (ts == 2'b10 && tc && ta == {W{1'b1}})       e.tag = "R5 inc wrap";
    else if (ts == 2'b11 && !tc && ta == '0)        e.tag = "R5 dec wrap";
    else if (ts == 2'b00)                            e.tag = "R1 add";
    else if (ts == 2'b01)                            e.tag = "R2 sub";
    else if (ts == 2'b10)                            e.tag = "R3 pass/inc";
    else                                             e.tag = "R4 dec/pass";
    sb.push_back(e);
  endtask

  // Monitor: compare mid-cycle, inputs applied 1.5 ns earlier in the same cycle (R7)
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " R7 kind0"}, {co0, res0}, {e.co, e.res});
      check({e.tag, " kind1"},    {co1, res1}, {e.co, e.res});
      check("R6 kinds agree",     {co1, res1}, {co0, res0});
    end
  end

  initial begin
    a = '0; b = '0; sel = 2'b00; cin = 1'b0;
    #12;
    checks++;
    if ({co0, res0} !== '0) begin
      fails++;
      $display("FAIL R1 idle zero actual=%h expected=0", {co0, res0});
    end
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int ia = 0; ia < (1 << W); ia++)
          for (int ib = 0; ib < (1 << W); ib++)
            drive(W'(ia), W'(ib), 2'(s), 1'(c));
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule